// File: doc/BRIEF.md
# Multi-Format Stereo Audio Serial Transmitter

This block takes stereo sample pairs as parallel words and sends them out one bit at a time on a single data line. A bit clock and a word/frame clock go out with the data. The block is always the clock master. It makes both clocks from the system clock with a programmable divider, so each bit period is `2*HALF_DIV` system cycles long. A frame is 64 bit periods, split into two 32-period halves. Four framing formats can be selected: I2S, left-justified, right-justified and DSP frame-sync. They differ in where the first bit of a word sits relative to the frame-clock edge and in which clock level marks the left channel.

Samples arrive through a valid/ready handshake that is open for exactly one system cycle per frame, at the frame boundary. If no pair is offered at that point, the previous pair goes out again. The format select and the word width are captured at the same boundary. A frame that has started always completes in the format it began with.

Top module: `audio_serial_tx`

## Requirements
- R1: The bit clock has a period of 2*HALF_DIV system cycles, high for HALF_DIV and low for HALF_DIV. Every bit period begins with a falling bit-clock edge. After reset the bit clock, frame clock, data line and `pair_ready` are all low.
- R2: A frame lasts 64 bit periods. `pair_ready` is high for exactly one system cycle per frame: the final system cycle of bit period 63. A pair presented with `pair_valid` high in that cycle is sent in the following frame.
- R3: Samples are right-aligned on the input buses, so bit W-1 is the MSB for word width W. Every word goes out MSB first. Each bit period that carries no word bit drives the data line low.
- R4: Format code 0 (I2S). The frame clock is low during periods 0-31, which carry the left channel, and high during periods 32-63, which carry the right channel. The MSB goes out in period 1 (left) and period 33 (right).
- R5: Format code 1 (left-justified). The frame clock is high during periods 0-31 (left) and low during periods 32-63 (right). The MSB goes out in period 0 (left) and period 32 (right).
- R6: Format code 2 (right-justified). The frame clock follows the same levels as R5. The LSB goes out in period 31 (left) and period 63 (right).
- R7: Format code 3 (DSP). The frame clock is high only in period 63. The left MSB goes out in period 0, and the right word follows directly, with its MSB in period W.
- R8: If `pair_valid` is low in the `pair_ready` cycle, the previous pair is sent again unchanged.
- R9: The format select and word width are sampled only in the `pair_ready` cycle. A change to either during a frame has no effect until the next frame.
- R10: The word width is clamped to the range 8..24. A requested width above 24 acts as 24, and one below 8 acts as 8.
- R11: The data line and the frame clock change only at falling bit-clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fmt_sel | input | 2 | Framing format: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| word_bits | input | 5 | Requested word width in bits (clamped to 8..24) |
| pair_valid | input | 1 | A new stereo pair is offered |
| pair_ready | output | 1 | One-cycle frame-boundary acceptance strobe |
| left_smp | input | 24 | Left sample, right-aligned |
| right_smp | input | 24 | Right sample, right-aligned |
| bclk_out | output | 1 | Bit clock |
| fclk_out | output | 1 | Word/frame clock |
| sdata_out | output | 1 | Serial data |

## Verification
Each format is driven with left and right samples that differ from each other and whose bit patterns are asymmetric. A whole captured frame therefore exposes a one-period offset error, swapped channel polarity, a reversed bit order or a swapped channel.

Each format also runs at a different word width. This shows whether the word is cut at the correct MSB and whether the unused periods stay low. In the DSP case it shows that the right word starts exactly W periods into the frame.

Two further sequences target the boundary behaviour. One changes the format and width in the middle of a frame and then leaves `pair_valid` low, which separates "captured at the boundary" from "followed live" and checks that the old pair is repeated. The other uses out-of-range widths to exercise the clamp.

// File: rtl/asp_pkg.sv
// Shared definitions for the audio serial transmitter.
package asp_pkg;
    // Framing format codes; the numeric values are the fmt_sel encoding.
    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;
endpackage

// File: rtl/asp_bit_timer.sv
// Bit-clock and slot timing generator.
// Divides the system clock into bit periods of 2*HALF_DIV cycles. The bit
// clock is low for the first half of each period and high for the second.
// The slot counter advances at each falling edge and wraps after FRAME_BITS
// periods. Assumes HALF_DIV >= 1 and FRAME_BITS >= 2.
module asp_bit_timer #(
    parameter int HALF_DIV   = 2,
    parameter int FRAME_BITS = 64,
    parameter int SW         = $clog2(FRAME_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic          bclk,
    output logic [SW-1:0] slot,
    output logic          frame_wrap
);
    localparam int DIV = 2 * HALF_DIV;
    localparam int DW  = (DIV > 1) ? $clog2(DIV) : 1;

    logic [DW-1:0] div_q;
    logic [SW-1:0] slot_q;
    logic          bclk_q;
    logic          rise_tick;
    logic          fall_tick;

    assign rise_tick  = (div_q == DW'(HALF_DIV - 1));
    assign fall_tick  = (div_q == DW'(DIV - 1));
    assign frame_wrap = fall_tick && (slot_q == SW'(FRAME_BITS - 1));

    // Divider: counts system cycles within one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n)         div_q <= '0;
        else if (fall_tick) div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Bit clock level: rises at mid-period, falls at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n)         bclk_q <= 1'b0;
        else if (rise_tick) bclk_q <= 1'b1;
        else if (fall_tick) bclk_q <= 1'b0;
    end

    // Slot counter: advances at each falling edge and wraps per frame.
    always_ff @(posedge clk) begin
        if (!rst_n)          slot_q <= '0;
        else if (frame_wrap) slot_q <= '0;
        else if (fall_tick)  slot_q <= slot_q + 1'b1;
    end

    assign bclk = bclk_q;
    assign slot = slot_q;
endmodule

// File: rtl/asp_frame_latch.sv
// Frame-boundary capture of the sample pair and the configuration.
// At load_en the format and the clamped word width are always taken. The
// samples are taken only when pair_valid is also high; otherwise the old
// pair is kept for repetition. Assumes MIN_W <= MAX_W.
module asp_frame_latch
    import asp_pkg::*;
#(
    parameter int MAX_W = 24,
    parameter int MIN_W = 8,
    parameter int WW    = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             pair_valid,
    input  logic [MAX_W-1:0] left_in,
    input  logic [MAX_W-1:0] right_in,
    input  logic [1:0]       fmt_in,
    input  logic [WW-1:0]    word_in,
    output logic [MAX_W-1:0] left_q,
    output logic [MAX_W-1:0] right_q,
    output fmt_e             fmt_q,
    output logic [WW-1:0]    word_q
);
    logic [WW-1:0] word_clamped;

    // Clamp the requested width into the supported range.
    always_comb begin
        if (word_in > WW'(MAX_W))      word_clamped = WW'(MAX_W);
        else if (word_in < WW'(MIN_W)) word_clamped = WW'(MIN_W);
        else                           word_clamped = word_in;
    end

    // Configuration capture: once per frame, unconditionally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fmt_q  <= FMT_I2S;
            word_q <= WW'(MAX_W);
        end else if (load_en) begin
            fmt_q  <= fmt_e'(fmt_in);
            word_q <= word_clamped;
        end
    end

    // Sample capture: only when a pair is offered at the boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q  <= '0;
            right_q <= '0;
        end else if (load_en && pair_valid) begin
            left_q  <= left_in;
            right_q <= right_in;
        end
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> ($stable(fmt_q) && $stable(word_q)));  // R9
    AST_WORD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_q >= WW'(MIN_W)) && (word_q <= WW'(MAX_W)));  // R10
    AST_PAIR_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_en && pair_valid) |=> ($stable(left_q) && $stable(right_q)));  // R8
endmodule

// File: rtl/asp_slot_mapper.sv
// Combinational slot-to-bit mapper.
// From the current slot, the format and the word width it chooses the frame
// clock level and the sample bit for the data line. Offsets per format:
// I2S starts one slot after the half boundary, left-justified starts at it,
// right-justified ends at the last slot of the half, and DSP packs left then
// right from slot 0. Assumes FRAME_BITS = 2*SLOT_BITS and MAX_W < SLOT_BITS.
module asp_slot_mapper
    import asp_pkg::*;
#(
    parameter int MAX_W     = 24,
    parameter int SLOT_BITS = 32,
    parameter int WW        = $clog2(MAX_W + 1),
    parameter int SW        = $clog2(2 * SLOT_BITS)
) (
    input  logic [SW-1:0]    slot,
    input  fmt_e             fmt,
    input  logic [WW-1:0]    word,
    input  logic [MAX_W-1:0] left_s,
    input  logic [MAX_W-1:0] right_s,
    output logic             fclk,
    output logic             sdata
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int IW         = $clog2(MAX_W);

    int            s_i;
    int            w_i;
    int            pos;
    int            off;
    int            k;
    logic          half;
    logic          active;
    logic          use_r;
    logic [IW-1:0] sel;

    // Slot decode: frame clock level and which sample bit, if any, is sent.
    always_comb begin
        s_i    = int'(slot);
        w_i    = int'(word);
        half   = (s_i >= SLOT_BITS);
        pos    = half ? (s_i - SLOT_BITS) : s_i;
        off    = 0;
        k      = 0;
        active = 1'b0;
        use_r  = 1'b0;
        fclk   = 1'b0;
        case (fmt)
            FMT_I2S: begin
                fclk = half;
                off  = 1;
            end
            FMT_LJ: begin
                fclk = !half;
                off  = 0;
            end
            FMT_RJ: begin
                fclk = !half;
                off  = SLOT_BITS - w_i;
            end
            default: begin
                fclk = (s_i == FRAME_BITS - 1);
            end
        endcase
        if (fmt == FMT_DSP) begin
            if (s_i < w_i) begin
                active = 1'b1;
                k      = s_i;
                use_r  = 1'b0;
            end else if (s_i < 2 * w_i) begin
                active = 1'b1;
                k      = s_i - w_i;
                use_r  = 1'b1;
            end
        end else begin
            k      = pos - off;
            active = (k >= 0) && (k < w_i);
            use_r  = half;
        end
        sel   = active ? IW'(w_i - 1 - k) : '0;
        sdata = active && (use_r ? right_s[sel] : left_s[sel]);
    end
endmodule

// File: rtl/audio_serial_tx.sv
// Multi-format stereo audio serial transmitter (clock master).
// Ties together the bit timer, the frame-boundary latch and the slot mapper.
// The outputs are decoded from registered state only, so they can change only
// on the system-clock edge where the bit clock falls. Assumes MAX_W < SLOT_BITS.
module audio_serial_tx
    import asp_pkg::*;
#(
    parameter int MAX_W     = 24,
    parameter int MIN_W     = 8,
    parameter int SLOT_BITS = 32,
    parameter int HALF_DIV  = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [1:0]                  fmt_sel,
    input  logic [$clog2(MAX_W+1)-1:0]  word_bits,
    input  logic                        pair_valid,
    output logic                        pair_ready,
    input  logic [MAX_W-1:0]            left_smp,
    input  logic [MAX_W-1:0]            right_smp,
    output logic                        bclk_out,
    output logic                        fclk_out,
    output logic                        sdata_out
);
    localparam int FRAME_BITS = 2 * SLOT_BITS;
    localparam int SW         = $clog2(FRAME_BITS);
    localparam int WW         = $clog2(MAX_W + 1);

    logic [SW-1:0]    slot;
    logic             frame_wrap;
    logic [MAX_W-1:0] left_q;
    logic [MAX_W-1:0] right_q;
    fmt_e             fmt_q;
    logic [WW-1:0]    word_q;

    asp_bit_timer #(
        .HALF_DIV   (HALF_DIV),
        .FRAME_BITS (FRAME_BITS),
        .SW         (SW)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .bclk       (bclk_out),
        .slot       (slot),
        .frame_wrap (frame_wrap)
    );

    asp_frame_latch #(
        .MAX_W (MAX_W),
        .MIN_W (MIN_W),
        .WW    (WW)
    ) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (frame_wrap),
        .pair_valid (pair_valid),
        .left_in    (left_smp),
        .right_in   (right_smp),
        .fmt_in     (fmt_sel),
        .word_in    (word_bits),
        .left_q     (left_q),
        .right_q    (right_q),
        .fmt_q      (fmt_q),
        .word_q     (word_q)
    );

    asp_slot_mapper #(
        .MAX_W     (MAX_W),
        .SLOT_BITS (SLOT_BITS),
        .WW        (WW),
        .SW        (SW)
    ) u_mapper (
        .slot    (slot),
        .fmt     (fmt_q),
        .word    (word_q),
        .left_s  (left_q),
        .right_s (right_q),
        .fclk    (fclk_out),
        .sdata   (sdata_out)
    );

    // Handshake: acceptance is open only in the frame-boundary cycle.
    assign pair_ready = frame_wrap;

    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_ready |=> !pair_ready);  // R2
    AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sdata_out) |-> $fell(bclk_out));  // R11
    AST_FCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fclk_out) |-> $fell(bclk_out));  // R11
endmodule

// File: tb/test_audio_serial_tx.sv
module test_audio_serial_tx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [4:0]  word_bits = 5'd24;
    logic        pair_valid = 1'b0;
    logic        pair_ready;
    logic [23:0] left_smp = '0;
    logic [23:0] right_smp = '0;
    logic        bclk_out;
    logic        fclk_out;
    logic        sdata_out;

    int n_tests = 0;
    int n_fail  = 0;
    int edge_bad = 0;
    logic mon_en = 1'b0;
    logic prev_s, prev_f, prev_b;
    logic [63:0] cap_d, cap_f;

    always #4 clk = ~clk;  // 125 MHz

    audio_serial_tx i_audio_serial_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt_sel    (fmt_sel),
        .word_bits  (word_bits),
        .pair_valid (pair_valid),
        .pair_ready (pair_ready),
        .left_smp   (left_smp),
        .right_smp  (right_smp),
        .bclk_out   (bclk_out),
        .fclk_out   (fclk_out),
        .sdata_out  (sdata_out)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int clampw(input int w);
        if (w > 24) return 24;
        if (w < 8) return 8;
        return w;
    endfunction

    // Expected data line per period, written from R3..R7.
    function automatic logic exp_d(input int f, input int w, input logic [23:0] l,
                                   input logic [23:0] r, input int s);
        int wc = clampw(w);
        int p = s % 32;
        int off;
        int k;
        logic [23:0] smp = (s >= 32) ? r : l;
        if (f == 3) begin
            if (s < wc) return l[wc-1-s];
            if (s < 2*wc) return r[2*wc-1-s];
            return 1'b0;
        end
        off = (f == 0) ? 1 : (f == 1) ? 0 : 32 - wc;
        k = p - off;
        if (k >= 0 && k < wc) return smp[wc-1-k];
        return 1'b0;
    endfunction

    function automatic logic exp_f(input int f, input int s);
        case (f)
            0: return s >= 32;
            1, 2: return s < 32;
            default: return s == 63;
        endcase
    endfunction

    // Wait until the boundary cycle; the frame starts at the following edge.
    task automatic wait_boundary();
        @(negedge clk);
        while (!pair_ready) @(negedge clk);
    endtask

    task automatic capture_frame();
        for (int k = 0; k < 64; k++) begin
            @(posedge bclk_out);
            #1;
            cap_d[k] = sdata_out;
            cap_f[k] = fclk_out;
        end
    endtask

    task automatic compare_frame(input string req, input int f, input int w,
                                 input logic [23:0] l, input logic [23:0] r);
        logic [63:0] ed, ef;
        for (int k = 0; k < 64; k++) begin
            ed[k] = exp_d(f, w, l, r, k);
            ef[k] = exp_f(f, k);
        end
        chk({req, " data"}, cap_d, ed);
        chk({req, " fclk"}, cap_f, ef);
    endtask

    // Offer a pair with a config at the next boundary, then capture that frame.
    task automatic send_and_check(input string req, input int f, input int w,
                                  input logic [23:0] l, input logic [23:0] r);
        @(negedge clk);
        fmt_sel = 2'(f);
        word_bits = 5'(w);
        left_smp = l;
        right_smp = r;
        pair_valid = 1'b1;
        wait_boundary();
        @(negedge clk);
        pair_valid = 1'b0;
        left_smp = 24'h0;
        right_smp = 24'h0;
        capture_frame();
        compare_frame(req, f, w, l, r);
    endtask

    task automatic t_reset();
        chk("R1 reset bclk", 64'(bclk_out), 64'd0);
        chk("R1 reset fclk", 64'(fclk_out), 64'd0);
        chk("R1 reset sdata", 64'(sdata_out), 64'd0);
        chk("R1 reset ready", 64'(pair_ready), 64'd0);
    endtask

    task automatic t_clocking();
        time t0, t1, t2;
        int rdy;
        @(posedge bclk_out); t0 = $time;
        @(negedge bclk_out); t1 = $time;
        @(posedge bclk_out); t2 = $time;
        chk("R1 bclk period ns", 64'(t2 - t0), 64'd32);
        chk("R1 bclk high ns", 64'(t1 - t0), 64'd16);
        wait_boundary();
        rdy = 0;
        for (int c = 0; c < 256; c++) begin
            @(negedge clk);
            if (pair_ready) rdy++;
        end
        chk("R2 ready cycles per frame", 64'(rdy), 64'd1);
        chk("R2 ready at frame end", 64'(pair_ready), 64'd1);
    endtask

    task automatic t_formats();
        send_and_check("R4 i2s w24", 0, 24, 24'hA5C3F1, 24'h3C0FE7);
        send_and_check("R5 lj w16", 1, 16, 24'h12B4D9, 24'h77E102);
        send_and_check("R6 rj w20", 2, 20, 24'h0C3A5E, 24'hF81B63);
        send_and_check("R7 dsp w24", 3, 24, 24'h9E2471, 24'h5B0DC8);
        send_and_check("R7 R3 dsp w12", 3, 12, 24'hFFF9A3, 24'hFFF5C6);
    endtask

    task automatic t_midframe_and_repeat();
        send_and_check("R9 start i2s", 0, 18, 24'h2D96B, 24'h1A3C5);
        // Mid-frame change of format and width while the next frame runs.
        wait_boundary();
        @(negedge clk);
        fmt_sel = 2'd1;
        word_bits = 5'd12;
        capture_frame();
        compare_frame("R9 R8 held i2s", 0, 18, 24'h2D96B, 24'h1A3C5);
        wait_boundary();
        @(negedge clk);
        capture_frame();
        compare_frame("R8 R9 repeat lj", 1, 12, 24'h2D96B, 24'h1A3C5);
    endtask

    task automatic t_clamp();
        send_and_check("R10 clamp high", 1, 30, 24'hC1E2F3, 24'h4A5B6C);
        send_and_check("R10 clamp low", 2, 3, 24'h000A5, 24'h0005A);
    endtask

    // Monitor for R11: data and frame clock move only with a falling bit clock.
    always @(negedge clk) begin
        if (mon_en) begin
            if ((sdata_out !== prev_s || fclk_out !== prev_f) && !(prev_b === 1'b1 && bclk_out === 1'b0))
                edge_bad++;
        end
        prev_s = sdata_out;
        prev_f = fclk_out;
        prev_b = bclk_out;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        mon_en = 1'b1;
        t_clocking();
        t_formats();
        t_midframe_and_repeat();
        t_clamp();
        chk("R11 edges outside bclk fall", 64'(edge_bad), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule